// File: doc/BRIEF.md
# Low-Confidence Branch Fetch Throttle

This block decides when the front end should stop fetching because too many weakly predicted branches are still in flight. A confidence estimator elsewhere marks each predicted branch as strong or weak. Every weak branch that enters the pipeline raises an occupancy count by one. Every weak branch that resolves lowers the count by one. A flush empties the count.

The stall output rises once the count is strictly larger than a programmable limit supplied on an input port. A limit of zero therefore stalls fetch as soon as one weak branch is pending. Larger limits allow several weak branches to run ahead before fetch is held, which trades wasted speculative work against lost throughput. The stall is a registered output. It reflects the count and limit of the previous cycle, so the logic that consumes it sees a clean flop output.

Top module: `fetch_gate_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the stall output is 0 and the occupancy count is 0.
- R2: A cycle with the fetch-side weak-branch strobe high, the resolve strobe low and flush low raises the count by one.
- R3: A cycle with the resolve strobe high, the fetch-side strobe low and flush low lowers the count by one.
- R4: A cycle with both strobes high and flush low leaves the count unchanged.
- R5: On each clock edge where flush is low, the stall output loads 1 exactly when the count before that edge is strictly greater than the limit before that edge; otherwise it loads 0.
- R6: The count saturates at 2^CNT_W-1. With CNT_W=4 this is 15. Further increments hold it at 15, and a limit of 15 never produces a stall.
- R7: A resolve strobe while the count is 0 leaves the count at 0. The count never wraps.
- R8: A flush clears the count to 0 and drives the stall output to 0 on the same clock edge. Flush takes priority over both strobes.
- R9: With the limit at 0, the stall output is 1 on the cycle after any cycle in which at least one weak branch is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lc_fetch_i | input | 1 | A weak-confidence branch entered the pipeline this cycle |
| lc_resolve_i | input | 1 | A weak-confidence branch resolved this cycle |
| flush_i | input | 1 | Pipeline flush; clears the occupancy count |
| limit_i | input | CNT_W | Stall limit N; stall when count > N |
| stall_o | output | 1 | Registered fetch stall request |

## Verification
The occupancy count is internal, so a wrong count shows at the ports only through the stall output. A count that is one too high or too low becomes visible one cycle after it crosses the current limit. The bench therefore moves the limit across the expected count to expose a count that has drifted, wrapped or failed to saturate. A wrapped count, from a missed saturation or an underflow, appears as a stall that is missing or spurious on the cycle after the limit is compared against it. A flush that is not honoured shows as a stall that stays high one cycle after the flush.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  // Next occupancy value: clear wins, then a single step with saturation at both ends.
  function automatic int unsigned fgc_next_count(input int unsigned cur,
                                                 input int unsigned maxv,
                                                 input logic up,
                                                 input logic dn,
                                                 input logic clr);
    int unsigned nxt;
    nxt = cur;
    if (clr)
      nxt = 0;
    else if (up && !dn && cur < maxv)
      nxt = cur + 1;
    else if (dn && !up && cur > 0)
      nxt = cur - 1;
    return nxt;
  endfunction

  // Strict comparison against the limit.
  function automatic logic fgc_over_limit(input int unsigned cnt,
                                          input int unsigned lim);
    return cnt > lim;
  endfunction

endpackage

// File: rtl/fgc_event_decode.sv
module fgc_event_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic lc_fetch_i,
  input  logic lc_resolve_i,
  input  logic flush_i,
  output logic ev_up_o,
  output logic ev_dn_o,
  output logic ev_clr_o
);

  // Exactly one action (or none) per cycle; flush has priority.
  assign ev_clr_o = flush_i;
  assign ev_up_o  = lc_fetch_i && !lc_resolve_i && !flush_i;
  assign ev_dn_o  = lc_resolve_i && !lc_fetch_i && !flush_i;

  // R4 and R8: decoded actions never overlap.
  assert_one_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_up_o, ev_dn_o, ev_clr_o}));

  // R8: a flush suppresses both step events.
  assert_flush_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !(ev_up_o || ev_dn_o));

endmodule

// File: rtl/fgc_occupancy_counter.sv
module fgc_occupancy_counter
  import fgc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_up_i,
  input  logic             ev_dn_i,
  input  logic             ev_clr_i,
  output logic [CNT_W-1:0] count_o
);

  localparam int unsigned MAXV = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  assign count_d = CNT_W'(fgc_next_count(32'(count_q), MAXV, ev_up_i, ev_dn_i, ev_clr_i));

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= '0;
    else
      count_q <= count_d;
  end

  assign count_o = count_q;

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up_i && count_q != CNT_W'(MAXV)) |=> count_q == $past(count_q) + 1'b1);

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dn_i && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_up_i && !ev_dn_i && !ev_clr_i) |=> $stable(count_q));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up_i && count_q == CNT_W'(MAXV)) |=> count_q == CNT_W'(MAXV));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dn_i && count_q == '0) |=> count_q == '0);

  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr_i |=> count_q == '0);

endmodule

// File: rtl/fgc_stall_reg.sv
module fgc_stall_reg
  import fgc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             clr_i,
  output logic             stall_o
);

  logic over_w;
  logic stall_q;

  assign over_w = fgc_over_limit(32'(count_i), 32'(limit_i));

  always_ff @(posedge clk) begin
    if (!rst_n)
      stall_q <= 1'b0;
    else
      stall_q <= over_w && !clr_i;
  end

  assign stall_o = stall_q;

  // R5: the stall reflects the previous cycle's count against the previous cycle's limit.
  assert_stall_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> stall_q == ($past(count_i) > $past(limit_i)));

  // R8: a flush drops the stall on the next edge.
  assert_flush_unstall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !stall_q);

  // R9: a zero limit with anything outstanding yields a stall.
  assert_zero_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && limit_i == '0 && count_i != '0) |=> stall_q);

endmodule

// File: rtl/fetch_gate_ctrl.sv
module fetch_gate_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lc_fetch_i,
  input  logic             lc_resolve_i,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             stall_o
);

  logic             ev_up;
  logic             ev_dn;
  logic             ev_clr;
  logic [CNT_W-1:0] occ_count;

  fgc_event_decode u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .lc_fetch_i   (lc_fetch_i),
    .lc_resolve_i (lc_resolve_i),
    .flush_i      (flush_i),
    .ev_up_o      (ev_up),
    .ev_dn_o      (ev_dn),
    .ev_clr_o     (ev_clr)
  );

  fgc_occupancy_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_up_i  (ev_up),
    .ev_dn_i  (ev_dn),
    .ev_clr_i (ev_clr),
    .count_o  (occ_count)
  );

  fgc_stall_reg #(.CNT_W(CNT_W)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_i (occ_count),
    .limit_i (limit_i),
    .clr_i   (ev_clr),
    .stall_o (stall_o)
  );

  // R1: one cycle after reset the stall is low.
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> !stall_o);

endmodule

// File: tb/sim_fetch_gate_ctrl.sv
`timescale 1ns/1ps
module sim_fetch_gate_ctrl;

  localparam int CNT_W = 4;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lc_fetch_i = 1'b0;
  logic             lc_resolve_i = 1'b0;
  logic             flush_i = 1'b0;
  logic [CNT_W-1:0] limit_i = '0;
  logic             stall_o;

  int errors = 0;
  int checks = 0;
  int m_cnt = 0;
  bit m_stall = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fetch_gate_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .lc_fetch_i   (lc_fetch_i),
    .lc_resolve_i (lc_resolve_i),
    .flush_i      (flush_i),
    .limit_i      (limit_i),
    .stall_o      (stall_o)
  );

  task automatic check(input string tag, input bit exp);
    checks++;
    if (stall_o !== exp) begin
      errors++;
      $display("FAIL %s stall actual=%0b expected=%0b at %0t", tag, stall_o, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, update the model at the edge, compare at the next negedge.
  task automatic step(input bit f, input bit r, input bit fl, input int lim, input string tag);
    lc_fetch_i   = f;
    lc_resolve_i = r;
    flush_i      = fl;
    limit_i      = CNT_W'(lim);
    @(posedge clk);
    m_stall = fl ? 1'b0 : (m_cnt > lim);
    if (fl) m_cnt = 0;
    else if (f && !r) m_cnt = (m_cnt < MAXV) ? m_cnt + 1 : m_cnt;
    else if (r && !f) m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
    @(negedge clk);
    check(tag, m_stall);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");

    // R2 / R5: three fetches against limit 2, stall appears only above it
    for (int i = 0; i < 3; i++) step(1, 0, 0, 2, "R2");
    step(0, 0, 0, 2, "R5");
    step(0, 0, 0, 3, "R5");
    step(0, 0, 0, 2, "R5");

    // R4: simultaneous strobes hold the count at 3
    for (int i = 0; i < 4; i++) step(1, 1, 0, 2, "R4");
    step(0, 0, 0, 2, "R4");

    // R3: resolves bring it to 2, strictly-greater test clears stall
    step(0, 1, 0, 2, "R3");
    step(0, 0, 0, 2, "R5");
    step(0, 0, 0, 1, "R3");
    step(0, 1, 0, 1, "R3");
    step(0, 1, 0, 0, "R3");
    step(0, 0, 0, 0, "R3");

    // R7: resolves at zero do not wrap
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R7");
    step(0, 0, 0, 14, "R7");
    step(1, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");

    // R6: saturation at 15
    for (int i = 0; i < 20; i++) step(1, 0, 0, 14, "R6");
    step(0, 0, 0, 14, "R6");
    step(0, 0, 0, 15, "R6");
    step(1, 0, 0, 15, "R6");
    step(0, 1, 0, 14, "R6");
    step(0, 0, 0, 14, "R6");
    step(0, 0, 0, 13, "R6");

    // R8: flush with strobes active clears everything
    step(1, 0, 1, 0, "R8");
    step(0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, "R8");
    step(0, 1, 1, 0, "R8");
    step(0, 0, 0, 0, "R8");

    // R5: live limit changes while the count is 5
    for (int i = 0; i < 5; i++) step(1, 0, 0, 8, "R2");
    step(0, 0, 0, 4, "R5");
    step(0, 0, 0, 5, "R5");
    step(0, 0, 0, 0, "R5");
    step(0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, "R8");

    finish_run();
  end

endmodule